// File: doc/BRIEF.md
# Two-Master Priority Bus Arbiter

This block decides which of two masters drives a shared bus: a processor core, which has the lower priority and owns the bus by default, and a transfer engine, which has the higher priority. Each master raises a request and is given a one-hot acknowledge. A master owns the bus for as long as its acknowledge stays high. The core also reports three status signals. One marks the end of a bus cycle. One is a lock flag that covers atomic multi-cycle sequences, such as split wide accesses and read-modify-write bit operations. One shows that the core is asleep. The arbiter takes the bus from the core only at a point where these signals allow it.

A handover in either direction always passes through a dead interval of `GAP_CYCLES` clocks (default 1) in which neither acknowledge is high. The transfer engine gives the bus back by dropping its request. The arbiter then returns the bus to the core. Reset is synchronous and active-high, and it leaves the core owning the bus.

Top module: `bus_arb2`

## Requirements
- R1: When `rst` is high at a clock edge, then after that edge `core_ack` is 1 and `xfer_ack` is 0.
- R2: `core_ack` and `xfer_ack` are never both 1.
- R3: The core owns the bus, and at a clock edge `xfer_req`=1, `core_req`=1, `core_cyc_end`=1 and `core_lock`=0. After that edge `core_ack` is 0. After the next edge `xfer_ack` is 1 (one dead clock at the default `GAP_CYCLES`=1).
- R4: The core owns the bus, and at an edge `core_req`=1, `core_cyc_end`=0 and `core_sleep`=0. After that edge the core still owns the bus, whatever `xfer_req` is.
- R5: The core owns the bus, and at an edge `core_lock`=1 and `core_sleep`=0. After that edge the core still owns the bus, even when `core_cyc_end`=1. No handover happens inside a locked span.
- R6: The core owns the bus, and at an edge `xfer_req`=1 and `core_sleep`=1. After that edge `core_ack` is 0, whatever `core_cyc_end` and `core_lock` are. `xfer_ack` rises one edge later.
- R7: The core owns the bus, and at an edge `xfer_req`=1, `core_req`=0 and `core_lock`=0. Handover starts at that edge: the idle core is at a cycle boundary.
- R8: While `xfer_ack`=1 and `xfer_req`=1 at an edge, `xfer_ack` stays 1 after that edge. The core's inputs have no effect on this.
- R9: When `xfer_ack`=1 and `xfer_req`=0 at an edge, both acknowledges are 0 after that edge. `core_ack` is 1 after the next edge.
- R10: When both masters request, the transfer engine is acknowledged at the first allowed point. When `xfer_req` is held low, the core keeps the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core requests the bus |
| xfer_req | input | 1 | Transfer engine requests the bus; dropping it releases the bus |
| core_cyc_end | input | 1 | Core is at the last clock of a bus cycle |
| core_lock | input | 1 | Core is inside an atomic multi-cycle sequence |
| core_sleep | input | 1 | Core is in sleep mode |
| core_ack | output | 1 | Core owns the bus |
| xfer_ack | output | 1 | Transfer engine owns the bus |

## Verification
The properties assume that `core_lock` is only high while `core_req` is high, and that a lock span is not cut short by anything other than sleep. The lock-hold and cycle-hold properties are written relative to the core's own status signals. The random stimulus asserts lock only together with a core request and holds it for several clocks at a time. Directed sequences cover these cases:
- a request that arrives mid-lock
- a request made while the core is asleep
- simultaneous requests
- back-to-back transfer bursts separated by a single idle clock

// File: rtl/bus_arb2_pkg.sv
package bus_arb2_pkg;
   typedef enum logic [1:0] {
      ST_CORE     = 2'd0,
      ST_GAP_XFER = 2'd1,
      ST_XFER     = 2'd2,
      ST_GAP_CORE = 2'd3
   } arb_state_e;
endpackage

// File: rtl/bus_arb2_window.sv
module bus_arb2_window #(
   parameter bit SLEEP_BYPASS = 1'b1
) (
   input  logic core_req,
   input  logic core_cyc_end,
   input  logic core_lock,
   input  logic core_sleep,
   output logic may_take
);
   logic boundary;
   // An idle core sits at a boundary; a locked one never does.
   assign boundary = !core_lock && (core_cyc_end || !core_req);

   generate
      if (SLEEP_BYPASS) begin : g_sleep
         assign may_take = core_sleep || boundary;
      end else begin : g_nosleep
         logic unused_sleep;
         assign unused_sleep = core_sleep;
         assign may_take = boundary;
      end
   endgenerate
endmodule

// File: rtl/bus_arb2_gap.sv
module bus_arb2_gap #(
   parameter int GAP_CYCLES = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic in_gap,
   output logic gap_done
);
   localparam int CW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(GAP_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !in_gap) cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign gap_done = in_gap && (cnt_q == LAST);
endmodule

// File: rtl/bus_arb2.sv
module bus_arb2 #(
   parameter int GAP_CYCLES   = 1,
   parameter bit SLEEP_BYPASS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic core_req,
   input  logic xfer_req,
   input  logic core_cyc_end,
   input  logic core_lock,
   input  logic core_sleep,
   output logic core_ack,
   output logic xfer_ack
);
   import bus_arb2_pkg::*;

   initial begin
      assert (GAP_CYCLES >= 1) else $error("bus_arb2: GAP_CYCLES must be at least 1");
   end

   arb_state_e state_q, state_d;
   logic       may_take;
   logic       in_gap;
   logic       gap_done;

   bus_arb2_window #(.SLEEP_BYPASS(SLEEP_BYPASS)) u_window (
      .core_req     (core_req),
      .core_cyc_end (core_cyc_end),
      .core_lock    (core_lock),
      .core_sleep   (core_sleep),
      .may_take     (may_take)
   );

   assign in_gap = (state_q == ST_GAP_XFER) || (state_q == ST_GAP_CORE);

   bus_arb2_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
      .clk      (clk),
      .rst      (rst),
      .in_gap   (in_gap),
      .gap_done (gap_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_CORE:     if (xfer_req && may_take) state_d = ST_GAP_XFER;
         ST_GAP_XFER: if (gap_done) state_d = ST_XFER;
         ST_XFER:     if (!xfer_req) state_d = ST_GAP_CORE;
         ST_GAP_CORE: if (gap_done) state_d = ST_CORE;
         default:     state_d = ST_CORE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_CORE;
      else     state_q <= state_d;
   end

   assign core_ack = (state_q == ST_CORE);
   assign xfer_ack = (state_q == ST_XFER);
endmodule

// File: rtl/bus_arb2_chk.sv
module bus_arb2_chk #(
   parameter bit SLEEP_BYPASS = 1'b1
) (
   input logic clk,
   input logic rst,
   input logic core_req,
   input logic xfer_req,
   input logic core_cyc_end,
   input logic core_lock,
   input logic core_sleep,
   input logic core_ack,
   input logic xfer_ack
);
   AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
      !(core_ack && xfer_ack)); // R2

   AST_HOLD_MID_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (core_ack && core_req && !core_cyc_end && !core_sleep) |=> core_ack); // R4

   AST_NO_LOCKED_HANDOVER: assert property (@(posedge clk) disable iff (rst)
      (core_ack && core_lock && !core_sleep) |=> core_ack); // R5

   AST_DEAD_CLOCK: assert property (@(posedge clk) disable iff (rst)
      $fell(core_ack) |-> !xfer_ack); // R3

   AST_XFER_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (xfer_ack && xfer_req) |=> xfer_ack); // R8

   AST_XFER_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (xfer_ack && !xfer_req) |=> (!xfer_ack && !core_ack)); // R9

   AST_NO_UNASKED_TAKE: assert property (@(posedge clk) disable iff (rst)
      (core_ack && !xfer_req) |=> core_ack); // R10

   generate
      if (SLEEP_BYPASS) begin : g_sleep_chk
         AST_SLEEP_TAKE: assert property (@(posedge clk) disable iff (rst)
            (core_ack && xfer_req && core_sleep) |=> !core_ack); // R6
      end
   endgenerate
endmodule

bind bus_arb2 bus_arb2_chk #(.SLEEP_BYPASS(SLEEP_BYPASS)) u_chk (.*);

// File: tb/tb_bus_arb2.sv
module tb_bus_arb2;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic core_req = 1'b0, xfer_req = 1'b0, core_cyc_end = 1'b0;
   logic core_lock = 1'b0, core_sleep = 1'b0;
   logic core_ack, xfer_ack;

   int n_chk  = 0;
   int n_fail = 0;
   int ph     = 0;   // 0 core, 1 gap->xfer, 2 xfer, 3 gap->core
   string tag = "R1";
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bus_arb2 dut (
      .clk(clk), .rst(rst), .core_req(core_req), .xfer_req(xfer_req),
      .core_cyc_end(core_cyc_end), .core_lock(core_lock), .core_sleep(core_sleep),
      .core_ack(core_ack), .xfer_ack(xfer_ack)
   );

   function automatic int next_ph(int p, bit cr, bit xr, bit ce, bit lk, bit sl);
      bit ok;
      ok = sl || (!lk && (ce || !cr));
      case (p)
         0:       return (xr && ok) ? 1 : 0;
         1:       return 2;
         2:       return xr ? 2 : 3;
         default: return 0;
      endcase
   endfunction

   function automatic string pick_tag(int p, bit cr, bit xr, bit ce, bit lk, bit sl);
      if (p == 0) begin
         if (!xr)               return "R10";
         if (sl)                return "R6";
         if (lk)                return "R5";
         if (!cr)               return "R7";
         if (!ce)               return "R4";
         return "R3";
      end
      if (p == 2) return xr ? "R8" : "R9";
      return "R3";
   endfunction

   task automatic check(string req, logic [1:0] act, logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {core_ack,xfer_ack} actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // Called just after a falling edge: drive, predict the next edge, compare.
   task automatic step(bit cr, bit xr, bit ce, bit lk, bit sl);
      core_req = cr; xfer_req = xr; core_cyc_end = ce; core_lock = lk; core_sleep = sl;
      tag = pick_tag(ph, cr, xr, ce, lk, sl);
      ph  = next_ph(ph, cr, xr, ce, lk, sl);
      @(negedge clk);
      check(tag, {core_ack, xfer_ack}, {ph == 0, ph == 2});
      n_chk++;
      if (core_ack && xfer_ack) begin
         n_fail++;
         $display("FAIL R2: {core_ack,xfer_ack} actual=11 expected=not 11 at %0t", $time);
      end
   endtask

   initial begin : wdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      int lock_left;
      bit cr, lk;
      void'($urandom(32'd1234));
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R1", {core_ack, xfer_ack}, 2'b10);
      rst = 1'b0;
      ph  = 0;

      // R5: request arrives mid-lock, with cycle ends inside the locked span
      step(1, 1, 0, 1, 0);
      step(1, 1, 1, 1, 0);
      step(1, 1, 1, 1, 0);
      step(1, 1, 0, 0, 0);   // R4: between cycles, still no boundary
      step(1, 1, 1, 0, 0);   // R3: boundary reached
      step(1, 1, 0, 0, 0);   // dead clock
      step(1, 1, 1, 1, 0);   // R8: core inputs ignored
      step(0, 0, 0, 0, 0);   // R9 release
      step(0, 0, 0, 0, 0);
      // R6: core asleep, locked and mid-cycle, still taken at once
      step(1, 1, 0, 1, 1);
      step(1, 1, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      step(1, 0, 0, 0, 0);
      // R10: simultaneous requests from an idle start
      step(1, 1, 1, 0, 0);
      step(1, 1, 0, 0, 0);
      // back-to-back bursts: one idle clock of the engine between them
      step(1, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      step(0, 1, 0, 0, 0);   // R7: idle core gives way
      step(0, 1, 0, 0, 0);
      step(0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0);

      // constrained random: lock only with a core request, held several clocks
      lock_left = 0;
      for (int i = 0; i < 4000; i++) begin
         cr = ($urandom_range(0, 3) != 0);
         if (lock_left == 0 && cr && $urandom_range(0, 5) == 0)
            lock_left = $urandom_range(2, 6);
         lk = (lock_left > 0);
         if (lk) begin cr = 1'b1; lock_left--; end
         step(cr, ($urandom_range(0, 2) != 0), ($urandom_range(0, 2) == 0), lk,
              ($urandom_range(0, 15) == 0));
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule